// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block fetches transmit descriptors from a ring in word-addressed memory and copies each descriptor's buffer into an internal transmit FIFO whose read side faces the line logic. A frame may occupy one descriptor or a chain of several. The engine tracks first and last segment markers, hands each descriptor back once its buffer has been copied, and writes completion or error status into the descriptor that ends the frame. Sticky interrupt flags record completion, missing descriptors, underflow and descriptor errors.

Two conditions stop the walk and put the engine in suspend: a descriptor still owned by software, or an underflow on the line side while a frame is being moved. In both cases the ring index is left on the descriptor after the last one closed, and work restarts only on a poll pulse. The line side is told when it may start sending: at a fill threshold, or only once a whole frame is stored when store-and-forward is selected.

Descriptor word 0 carries ownership (bit 31), interrupt-on-completion (bit 30), last segment (bit 29), first segment (bit 28), underflow status (bit 27) and descriptor-error status (bit 26). Word 1 carries the buffer word address in bits 31:16 and the buffer length in words in bits 15:0. The flag vector is: bit 0 transmit done, bit 1 buffer unavailable, bit 2 underflow, bit 3 descriptor error, bit 4 normal summary, bit 5 abnormal summary.

The controller states are IDLE, RD0 (read word 0), CHK0 (test ownership, read word 1), CHK1 (latch word 1), DECIDE, PRE0/PRE1/PRE2 (prefetch both words of the next slot), CPRD/CPWR (buffer word read and push), CLOSE, PROMO (adopt the prefetched descriptor), DERR, ABORT and SUSP. Transitions: IDLE to RD0 when run is high; RD0 to CHK0; CHK0 to CHK1 if owned, else to SUSP; CHK1 to DECIDE; DECIDE to DERR for a last segment of length zero, to PRE0 when the frame continues, else to CPRD; PRE0 to PRE1 to PRE2 to CPRD; CPRD to CLOSE when all words are moved, to CPWR when the FIFO has room, else it waits; CPWR to CPRD; CLOSE to RD0 (or IDLE if run is low) after a last segment, to PROMO if the prefetched slot is owned, else to SUSP; PROMO to DECIDE; DERR and ABORT to SUSP; SUSP to RD0 on a poll pulse. Any of DECIDE, PRE0-2, CPRD, CPWR moves to ABORT on an underflow while a frame is open.

Top module: `tdr_dma`

## Requirements
- R1: During and right after reset all flags are 0, no memory access is made, the FIFO level is 0 and line_go is 0.
- R2: A descriptor whose word 0 bit 31 is 0 is not processed; reading one enters suspend, sets flag bits 1 and 4, keeps the ring index on that slot, and nothing further happens until a poll_req pulse.
- R3: A descriptor's buffer (address word 1 bits 31:16, length in words bits 15:0) is pushed into the FIFO in address order; line_last is 1 only on the final word of a last-segment (bit 29) descriptor.
- R4: When bit 29 is 0 the next slot is prefetched before the copy; the intermediate descriptor is closed with bit 31 cleared and other bits unchanged; if the prefetched slot is not owned the engine suspends after that close with flags 1 and 4, leaving the partial frame in the FIFO.
- R5: A completed last-segment descriptor is written back with bits 31, 27 and 26 cleared and other bits kept; flags 0 and 4 are raised only when its bit 30 is set.
- R6: A pop on an empty FIFO while a frame is being copied aborts it: word 0 is written with bit 31 cleared and bit 27 set, flags 2 and 5 rise, the FIFO is emptied, the engine suspends and the index moves past that descriptor.
- R7: A pop on an empty FIFO while no frame is being copied changes no flag and no FIFO state.
- R8: A last-segment descriptor of length 0 is written back with bit 31 cleared and bit 26 set, pushes nothing, raises flags 3 and 5 (not 0), and suspends with the index on the following slot.
- R9: Slot i sits at RING_BASE + i*DESC_STRIDE; the index wraps from RING_LEN-1 to 0.
- R10: With sf_mode 0, line_go is 1 when the FIFO level is nonzero and at least tx_thresh, or a whole frame is stored; with sf_mode 1 only when a whole frame is stored.
- R11: Flags are sticky; a 1 in irq_clr clears only that bit, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run_en | input | 1 | Allows the engine to leave IDLE |
| poll_req | input | 1 | One-cycle pulse that restarts a suspended engine |
| irq_clr | input | 6 | Write-one-to-clear per flag |
| irq_flags | output | 6 | Sticky status flags |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read strobe |
| sf_mode | input | 1 | Store-and-forward start gating |
| tx_thresh | input | LVL_W | Start threshold in words |
| line_pop | input | 1 | Line side takes one word |
| line_data | output | 32 | Head word of the FIFO |
| line_last | output | 1 | Head word ends a frame |
| line_go | output | 1 | Line side may begin sending |
| fifo_level | output | LVL_W | Words held in the FIFO |

## Verification
A wrong ring index shows up as a write-back landing in the wrong slot, or as the wrong descriptor being adopted after a poll, within a few cycles of the next fetch. A stale segment flag shows on line_last at the FIFO head, and a lost open-frame marker shows as an underflow that is either ignored or aborts a frame that has not started. Because suspend must hold still, a misplaced transition is seen as an unexpected descriptor write or FIFO growth while the bench waits without a poll.

// File: rtl/tdr_pkg.sv
package tdr_pkg;
    localparam int WORD_W = 32;
    localparam int NFLAG  = 6;

    // descriptor word 0 bits
    localparam int OWN_B = 31;
    localparam int IC_B  = 30;
    localparam int LS_B  = 29;
    localparam int FS_B  = 28;
    localparam int UF_B  = 27;
    localparam int DE_B  = 26;

    // status flag positions
    localparam int FL_TI  = 0;
    localparam int FL_TU  = 1;
    localparam int FL_UNF = 2;
    localparam int FL_DE  = 3;
    localparam int FL_NIS = 4;
    localparam int FL_AIS = 5;

    typedef enum logic [3:0] {
        S_IDLE, S_RD0, S_CHK0, S_CHK1, S_DECIDE,
        S_PRE0, S_PRE1, S_PRE2, S_CPRD, S_CPWR,
        S_CLOSE, S_PROMO, S_DERR, S_ABORT, S_SUSP
    } tdr_state_e;
endpackage

// File: rtl/tdr_irq.sv
module tdr_irq #(
    parameter int NF = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic [NF-1:0] clr_i,
    output logic [NF-1:0] flags_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= (flags_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/tdr_fifo.sv
module tdr_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_last,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          pop_last,
    output logic          full,
    output logic          empty,
    output logic          underflow,
    output logic [LW-1:0] level,
    input  logic [LW-1:0] thresh,
    input  logic          sf_mode,
    output logic          go
);
    logic [DW:0]   store [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [LW-1:0] frames;
    logic          do_push, do_pop;

    assign full      = (level == LW'(DEPTH));
    assign empty     = (level == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign underflow = pop && empty;
    assign pop_data  = store[rp][DW-1:0];
    assign pop_last  = store[rp][DW];
    assign go        = (frames != '0) || (!sf_mode && !empty && (level >= thresh));

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push && !flush) store[wp] <= {push_last, push_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp <= '0; rp <= '0; level <= '0; frames <= '0;
        end else if (flush) begin
            wp <= '0; rp <= '0; level <= '0; frames <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            level  <= level + LW'(do_push) - LW'(do_pop);
            frames <= frames + LW'(do_push && push_last) - LW'(do_pop && pop_last);
        end
    end
endmodule

// File: rtl/tdr_dma.sv
module tdr_dma
    import tdr_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int RING_LEN    = 4,
    parameter int DESC_STRIDE = 2,
    parameter int RING_BASE   = 0,
    parameter int FIFO_DEPTH  = 8,
    localparam int IDX_W = (RING_LEN > 1) ? $clog2(RING_LEN) : 1,
    localparam int LVL_W = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              poll_req,
    input  logic [NFLAG-1:0]  irq_clr,
    output logic [NFLAG-1:0]  irq_flags,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              sf_mode,
    input  logic [LVL_W-1:0]  tx_thresh,
    input  logic              line_pop,
    output logic [WORD_W-1:0] line_data,
    output logic              line_last,
    output logic              line_go,
    output logic [LVL_W-1:0]  fifo_level
);
    localparam logic [WORD_W-1:0] OWN_M = WORD_W'(1) << OWN_B;
    localparam logic [WORD_W-1:0] UF_M  = WORD_W'(1) << UF_B;
    localparam logic [WORD_W-1:0] DE_M  = WORD_W'(1) << DE_B;

    tdr_state_e        state, nxt;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] cur_w0, cur_w1, sh_w0, sh_w1;
    logic [15:0]       cnt;
    logic              in_frame;

    logic              fifo_push, fifo_last, fifo_flush, fifo_full, fifo_empty, fifo_uf;
    logic [NFLAG-1:0]  flag_set;

    logic [15:0]       buf_len;
    logic [ADDR_W-1:0] slot_a, next_a, buf_a;
    logic [IDX_W-1:0]  idx_next;
    logic              abortable;

    function automatic logic [ADDR_W-1:0] slot_addr(input logic [IDX_W-1:0] i);
        return ADDR_W'(RING_BASE + int'(i) * DESC_STRIDE);
    endfunction

    assign idx_next  = (idx == IDX_W'(RING_LEN - 1)) ? '0 : idx + 1'b1;
    assign slot_a    = slot_addr(idx);
    assign next_a    = slot_addr(idx_next);
    assign buf_len   = cur_w1[15:0];
    assign buf_a     = ADDR_W'(cur_w1[31:16]) + ADDR_W'(cnt);
    assign abortable = in_frame && (state inside {S_DECIDE, S_PRE0, S_PRE1, S_PRE2, S_CPRD, S_CPWR});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (run_en) nxt = S_RD0;
            S_RD0:    nxt = S_CHK0;
            S_CHK0:   nxt = mem_rdata[OWN_B] ? S_CHK1 : S_SUSP;
            S_CHK1:   nxt = S_DECIDE;
            S_DECIDE: begin
                if (cur_w0[LS_B] && buf_len == '0) nxt = S_DERR;
                else if (!cur_w0[LS_B])            nxt = S_PRE0;
                else                               nxt = S_CPRD;
            end
            S_PRE0:   nxt = S_PRE1;
            S_PRE1:   nxt = S_PRE2;
            S_PRE2:   nxt = S_CPRD;
            S_CPRD: begin
                if (cnt == buf_len)  nxt = S_CLOSE;
                else if (!fifo_full) nxt = S_CPWR;
            end
            S_CPWR:   nxt = S_CPRD;
            S_CLOSE: begin
                if (cur_w0[LS_B])      nxt = run_en ? S_RD0 : S_IDLE;
                else if (sh_w0[OWN_B]) nxt = S_PROMO;
                else                   nxt = S_SUSP;
            end
            S_PROMO:  nxt = S_DECIDE;
            S_DERR:   nxt = S_SUSP;
            S_ABORT:  nxt = S_SUSP;
            S_SUSP:   if (poll_req) nxt = S_RD0;
            default:  nxt = S_IDLE;
        endcase
        if (fifo_uf && abortable) nxt = S_ABORT;
    end

    // outputs
    always_comb begin
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        fifo_push  = 1'b0;
        fifo_last  = 1'b0;
        fifo_flush = 1'b0;
        flag_set   = '0;
        unique case (state)
            S_RD0: begin
                mem_en   = 1'b1;
                mem_addr = slot_a;
            end
            S_CHK0: begin
                if (mem_rdata[OWN_B]) begin
                    mem_en   = 1'b1;
                    mem_addr = slot_a + ADDR_W'(1);
                end else begin
                    flag_set[FL_TU]  = 1'b1;
                    flag_set[FL_NIS] = 1'b1;
                end
            end
            S_PRE0: begin
                mem_en   = 1'b1;
                mem_addr = next_a;
            end
            S_PRE1: begin
                mem_en   = 1'b1;
                mem_addr = next_a + ADDR_W'(1);
            end
            S_CPRD: begin
                if (cnt != buf_len && !fifo_full) begin
                    mem_en   = 1'b1;
                    mem_addr = buf_a;
                end
            end
            S_CPWR: begin
                fifo_push = 1'b1;
                fifo_last = cur_w0[LS_B] && (cnt == buf_len - 16'd1);
            end
            S_CLOSE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot_a;
                mem_wdata = cur_w0 & ~(OWN_M | UF_M | DE_M);
                if (cur_w0[LS_B] && cur_w0[IC_B]) begin
                    flag_set[FL_TI]  = 1'b1;
                    flag_set[FL_NIS] = 1'b1;
                end
                if (!cur_w0[LS_B] && !sh_w0[OWN_B]) begin
                    flag_set[FL_TU]  = 1'b1;
                    flag_set[FL_NIS] = 1'b1;
                end
            end
            S_DERR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot_a;
                mem_wdata = (cur_w0 & ~(OWN_M | UF_M)) | DE_M;
                flag_set[FL_DE]  = 1'b1;
                flag_set[FL_AIS] = 1'b1;
            end
            S_ABORT: begin
                mem_en     = 1'b1;
                mem_we     = 1'b1;
                mem_addr   = slot_a;
                mem_wdata  = (cur_w0 & ~(OWN_M | DE_M)) | UF_M;
                fifo_flush = 1'b1;
                flag_set[FL_UNF] = 1'b1;
                flag_set[FL_AIS] = 1'b1;
            end
            default: ;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            cur_w0   <= '0;
            cur_w1   <= '0;
            sh_w0    <= '0;
            sh_w1    <= '0;
            cnt      <= '0;
            in_frame <= 1'b0;
        end else begin
            unique case (state)
                S_CHK0: begin
                    in_frame <= mem_rdata[OWN_B];
                    if (mem_rdata[OWN_B]) cur_w0 <= mem_rdata;
                end
                S_CHK1:   cur_w1 <= mem_rdata;
                S_DECIDE: cnt <= '0;
                S_PRE1:   sh_w0 <= mem_rdata;
                S_PRE2:   sh_w1 <= mem_rdata;
                S_CPWR:   cnt <= cnt + 16'd1;
                S_CLOSE: begin
                    idx <= idx_next;
                    if (cur_w0[LS_B] || !sh_w0[OWN_B]) in_frame <= 1'b0;
                end
                S_PROMO: begin
                    cur_w0 <= sh_w0;
                    cur_w1 <= sh_w1;
                end
                S_DERR, S_ABORT: begin
                    idx      <= idx_next;
                    in_frame <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    tdr_fifo #(.DW(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (fifo_flush),
        .push      (fifo_push),
        .push_data (mem_rdata),
        .push_last (fifo_last),
        .pop       (line_pop),
        .pop_data  (line_data),
        .pop_last  (line_last),
        .full      (fifo_full),
        .empty     (fifo_empty),
        .underflow (fifo_uf),
        .level     (fifo_level),
        .thresh    (tx_thresh),
        .sf_mode   (sf_mode),
        .go        (line_go)
    );

    tdr_irq #(.NF(NFLAG)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (flag_set),
        .clr_i   (irq_clr),
        .flags_o (irq_flags)
    );
endmodule

// File: rtl/tdr_dma_chk.sv
module tdr_dma_chk
    import tdr_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int RING_LEN    = 4,
    parameter int DESC_STRIDE = 2,
    parameter int RING_BASE   = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NFLAG-1:0]  irq_clr,
    input logic [NFLAG-1:0]  irq_flags,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              fifo_push,
    input logic              fifo_full
);
    p_flags_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr == '0) |=> ((irq_flags & $past(irq_flags)) == $past(irq_flags)));

    p_push_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> !fifo_full);

    p_handback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> !mem_wdata[OWN_B]);

    p_uf_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && mem_wdata[UF_B]) |=> (irq_flags[FL_UNF] && irq_flags[FL_AIS]));

    p_de_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && mem_wdata[DE_B]) |=> (irq_flags[FL_DE] && irq_flags[FL_AIS]));

    p_ring_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> ((int'(mem_addr) >= RING_BASE) &&
                               (int'(mem_addr) < RING_BASE + RING_LEN * DESC_STRIDE)));
endmodule

bind tdr_dma tdr_dma_chk #(
    .ADDR_W      (ADDR_W),
    .RING_LEN    (RING_LEN),
    .DESC_STRIDE (DESC_STRIDE),
    .RING_BASE   (RING_BASE)
) u_tdr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_clr   (irq_clr),
    .irq_flags (irq_flags),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .fifo_push (fifo_push),
    .fifo_full (fifo_full)
);

// File: tb/tdr_dma_bench.sv
`timescale 1ns/1ps
module tdr_dma_bench;
    localparam int LVL_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        poll_req = 1'b0;
    logic [5:0]  irq_clr = '0;
    logic [5:0]  irq_flags;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        sf_mode = 1'b0;
    logic [LVL_W-1:0] tx_thresh = 4'd2;
    logic        line_pop = 1'b0;
    logic [31:0] line_data;
    logic        line_last, line_go;
    logic [LVL_W-1:0] fifo_level;

    logic [31:0] mem [256];
    logic        tb_we = 1'b0;
    logic [7:0]  tb_a = '0;
    logic [31:0] tb_d = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [5:0] F_TI = 6'h01, F_TU = 6'h02, F_UNF = 6'h04,
                           F_DE = 6'h08, F_NIS = 6'h10, F_AIS = 6'h20;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (tb_we) mem[tb_a] <= tb_d;
        else if (mem_en) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    tdr_dma u_tdr_dma (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .poll_req(poll_req),
        .irq_clr(irq_clr), .irq_flags(irq_flags),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .sf_mode(sf_mode), .tx_thresh(tx_thresh), .line_pop(line_pop),
        .line_data(line_data), .line_last(line_last), .line_go(line_go),
        .fifo_level(fifo_level)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] a, input logic [31:0] d);
        tb_we = 1'b1; tb_a = a; tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic poll();
        poll_req = 1'b1;
        @(negedge clk);
        poll_req = 1'b0;
    endtask

    task automatic clear_all();
        irq_clr = 6'h3f;
        @(negedge clk);
        irq_clr = '0;
    endtask

    task automatic take(input string req, input logic [31:0] d, input logic l);
        chk(req, line_data, d);
        chk(req, {31'd0, line_last}, {31'd0, l});
        line_pop = 1'b1;
        @(negedge clk);
        line_pop = 1'b0;
    endtask

    task automatic t_reset();
        cyc(3);
        chk("R1 flags", {26'd0, irq_flags}, 32'd0);
        chk("R1 mem_en", {31'd0, mem_en}, 32'd0);
        chk("R1 level", {28'd0, fifo_level}, 32'd0);
        chk("R1 go", {31'd0, line_go}, 32'd0);
        for (int i = 0; i < 8; i++) put(8'(i), 32'd0);
        rst_n = 1'b1;
        cyc(2);
        // pops on an empty FIFO with no frame open
        line_pop = 1'b1;
        cyc(3);
        line_pop = 1'b0;
        cyc(1);
        chk("R7 flags", {26'd0, irq_flags}, 32'd0);
        chk("R7 level", {28'd0, fifo_level}, 32'd0);
    endtask

    task automatic t_single();
        put(8'h00, 32'hF000_0000);
        put(8'h01, {16'h0040, 16'd3});
        put(8'h40, 32'hA0);
        put(8'h41, 32'hA1);
        put(8'h42, 32'hA2);
        run_en = 1'b1;
        cyc(40);
        chk("R5 writeback", mem[0], 32'h7000_0000);
        chk("R5 R2 flags", {26'd0, irq_flags}, {26'd0, F_TI | F_NIS | F_TU});
        chk("R3 level", {28'd0, fifo_level}, 32'd3);
        chk("R10 go frame", {31'd0, line_go}, 32'd1);
        take("R3 w0", 32'hA0, 1'b0);
        take("R3 w1", 32'hA1, 1'b0);
        take("R3 w2", 32'hA2, 1'b1);
        clear_all();
        chk("R11 cleared", {26'd0, irq_flags}, 32'd0);
    endtask

    task automatic t_chain();
        put(8'h02, 32'h9000_0005);
        put(8'h03, {16'h0050, 16'd2});
        put(8'h04, 32'h2000_0003);
        put(8'h05, {16'h0060, 16'd1});
        put(8'h50, 32'hB0);
        put(8'h51, 32'hB1);
        put(8'h60, 32'hC0);
        poll();
        cyc(40);
        chk("R4 intermediate close", mem[2], 32'h1000_0005);
        chk("R4 flags", {26'd0, irq_flags}, {26'd0, F_TU | F_NIS});
        chk("R4 partial level", {28'd0, fifo_level}, 32'd2);
        chk("R2 untouched slot", mem[4], 32'h2000_0003);
        sf_mode = 1'b1;
        cyc(1);
        chk("R10 sf partial", {31'd0, line_go}, 32'd0);
        sf_mode = 1'b0;
        cyc(1);
        chk("R10 thresh met", {31'd0, line_go}, 32'd1);
        tx_thresh = 4'd3;
        cyc(1);
        chk("R10 thresh not met", {31'd0, line_go}, 32'd0);
        tx_thresh = 4'd2;
        clear_all();
        put(8'h04, 32'hA000_0003);
        cyc(20);
        chk("R2 no poll", mem[4], 32'hA000_0003);
        chk("R2 no poll level", {28'd0, fifo_level}, 32'd2);
        poll();
        cyc(40);
        chk("R5 last close", mem[4], 32'h2000_0003);
        chk("R5 no ic", {26'd0, irq_flags}, {26'd0, F_TU | F_NIS});
        sf_mode = 1'b1;
        cyc(1);
        chk("R10 sf whole", {31'd0, line_go}, 32'd1);
        sf_mode = 1'b0;
        take("R3 chain0", 32'hB0, 1'b0);
        take("R4 chain1", 32'hB1, 1'b0);
        take("R4 chain2", 32'hC0, 1'b1);
        clear_all();
    endtask

    task automatic t_underflow();
        put(8'h06, 32'hB000_0000);
        put(8'h07, {16'h0070, 16'd6});
        line_pop = 1'b1;
        poll();
        cyc(30);
        line_pop = 1'b0;
        cyc(5);
        chk("R6 desc status", mem[6], 32'h3800_0000);
        chk("R6 flags", {26'd0, irq_flags}, {26'd0, F_UNF | F_AIS});
        chk("R6 flushed", {28'd0, fifo_level}, 32'd0);
        clear_all();
    endtask

    task automatic t_zero();
        put(8'h00, 32'hF000_0000);
        put(8'h01, {16'h0040, 16'd0});
        poll();
        cyc(30);
        chk("R8 R9 wrap status", mem[0], 32'h7400_0000);
        chk("R8 flags", {26'd0, irq_flags}, {26'd0, F_DE | F_AIS});
        chk("R8 nothing pushed", {28'd0, fifo_level}, 32'd0);
        irq_clr = F_DE;
        @(negedge clk);
        irq_clr = '0;
        chk("R11 single clear", {26'd0, irq_flags}, {26'd0, F_AIS});
        clear_all();
        put(8'h02, 32'hF000_0000);
        put(8'h03, {16'h0050, 16'd1});
        poll();
        cyc(30);
        chk("R8 next slot", mem[2], 32'h7000_0000);
        chk("R8 next flags", {26'd0, irq_flags}, {26'd0, F_TI | F_NIS | F_TU});
        take("R8 next data", 32'hB0, 1'b1);
    endtask

    initial begin
        t_reset();
        t_single();
        t_chain();
        t_underflow();
        t_zero();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule